// File: doc/BRIEF.md
# Per-Processor Interrupt Presenter

This block holds the interrupt state of one processor. It keeps a running priority for the processor. It also keeps a single slot for the interrupt currently offered to that processor: the slot holds the source number and the source's priority. A third register holds a local inter-processor interrupt (IPI) priority. The block drives a level interrupt line to the processor. It is asserted whenever the slot is occupied.

A source controller offers interrupts as a source number plus a priority. The block keeps an offer that beats both the running priority and the occupant of the slot. It hands every loser back on a reject strobe. The processor works the block through a four-operation command port: set the running priority, set the IPI priority, accept, and end-of-interrupt. Accept returns a 32-bit status word: the running priority in bits 31:24 and the held source number in bits 23:0, where 0 means empty. The block sends end-of-interrupt and resend-request strobes back to the source controller.

The slot is a three-state machine. The states are `SLOT_EMPTY`, `SLOT_SRC` (holds an external source) and `SLOT_IPI` (holds the local IPI, source number 2). The transitions are:
- `take_offer`: any state to `SLOT_SRC`.
- `present_ipi`: any state to `SLOT_IPI`.
- `accept`: any state to `SLOT_EMPTY`.
- `displace_by_run`: `SLOT_SRC` or `SLOT_IPI` to `SLOT_EMPTY`.

A lower priority number is more favoured. 0xFF means none.

Top module: `irq_presenter`

## Requirements
- R1: After reset the interrupt line is low and all strobes are idle. An accept issued first returns 0x00000000. After that accept the running priority is 0xFF.
- R2: An offer (`offer_valid` with a source number and priority) is taken into the slot when two conditions hold. Its priority must be strictly below the running priority. The slot must be empty, or must hold a priority strictly above the offer's. When the offer is taken, the interrupt line is high one cycle later.
- R3: An offer that fails R2 is returned: one cycle later `rej_valid` pulses with `rej_src` equal to the offered source number. The slot is unchanged.
- R4: When an offer is taken while the slot holds an external source, that held source is returned on the reject strobe one cycle later.
- R5: Accept (op code 2) pulses `rsp_valid` one cycle later. `rsp_word` then carries {running priority, held source} as they were before the command. The slot empties and the line drops. The running priority takes the held priority, which is 0xFF if the slot was empty.
- R6: Set-running (op code 0, new priority in `cmd_data[7:0]`) may lower the running priority to a value at or below the held priority. In that case the slot empties, the line drops, and a held external source is rejected.
- R7: Set-running may raise or keep the running priority while the slot is empty. In that case a resend request pulses. If the IPI priority is then below the new running priority, the IPI (source 2) is presented at the IPI priority.
- R8: Set-IPI (op code 1, value in `cmd_data[7:0]`) stores the IPI priority. If the value is strictly below the running priority, an IPI check runs. The check presents source 2 at that priority and rejects any held external source. Otherwise there is no presentation.
- R9: The IPI check leaves the slot alone when the slot already holds a priority at or below the IPI priority.
- R10: End-of-interrupt (op code 3) loads the running priority from `cmd_data[31:24]`. It pulses `eoi_valid` with `eoi_src` equal to `cmd_data[23:0]`. If the slot is empty, it then performs the resend of R7.
- R11: A held IPI that is displaced, whether by an offer or by a priority change, is never sent on the reject strobe.
- R12: Every strobe lasts one cycle and only follows a command or offer. An idle cycle produces no strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| offer_valid | input | 1 | Source controller offers an interrupt |
| offer_src | input | 24 | Offered source number (nonzero, not 2) |
| offer_prio | input | 8 | Offered priority |
| cmd_valid | input | 1 | Processor command strobe |
| cmd_op | input | 2 | 0 set-running, 1 set-IPI, 2 accept, 3 end-of-interrupt |
| cmd_data | input | 32 | Command operand |
| irq_out | output | 1 | Level interrupt to the processor |
| rsp_valid | output | 1 | Accept result valid |
| rsp_word | output | 32 | Accept result {priority, source} |
| rej_valid | output | 1 | Reject strobe to source controller |
| rej_src | output | 24 | Rejected source number |
| eoi_valid | output | 1 | End-of-interrupt strobe |
| eoi_src | output | 24 | Source number being retired |
| resend_req | output | 1 | Request to re-offer rejected sources |

## Verification
The hardest state to reach is a held IPI that loses the slot without a reject, as in R11. The slot must first hold source 2, which only happens through the IPI check. The stimulus gets there by setting an IPI priority and then retiring an interrupt while the slot is empty. The resend of R10 then presents the IPI. A more favoured offer follows, and the reject strobe must stay quiet. A second hard case is an IPI check that must do nothing (R9). It needs a held priority equal to the new IPI priority, so the sequence reuses the same IPI value while the IPI is still held.

// File: rtl/pres_pkg.sv
package pres_pkg;

    typedef enum logic [1:0] {
        OP_SET_RUN = 2'd0,
        OP_SET_IPI = 2'd1,
        OP_ACCEPT  = 2'd2,
        OP_EOI     = 2'd3
    } pres_op_e;

    typedef enum logic [1:0] {
        SLOT_EMPTY = 2'd0,
        SLOT_SRC   = 2'd1,
        SLOT_IPI   = 2'd2
    } slot_e;

endpackage

// File: rtl/pres_ipi_check.sv
module pres_ipi_check
    import pres_pkg::*;
#(
    parameter int PRIO_W = 8
) (
    input  slot_e              slot,
    input  logic [PRIO_W-1:0]  held_prio,
    input  logic [PRIO_W-1:0]  ipi_prio,
    output logic               take,
    output logic               drop_src
);
    // The IPI wins unless the slot already holds something at least as favoured.
    always_comb begin
        take     = !((slot != SLOT_EMPTY) && (held_prio <= ipi_prio));
        drop_src = take && (slot == SLOT_SRC);
    end
endmodule

// File: rtl/pres_offer_judge.sv
module pres_offer_judge
    import pres_pkg::*;
#(
    parameter int PRIO_W = 8
) (
    input  slot_e              slot,
    input  logic [PRIO_W-1:0]  run_prio,
    input  logic [PRIO_W-1:0]  held_prio,
    input  logic [PRIO_W-1:0]  offer_prio,
    output logic               take,
    output logic               drop_src
);
    logic beats_run;
    logic beats_held;

    always_comb begin
        beats_run  = offer_prio < run_prio;
        beats_held = (slot == SLOT_EMPTY) || (offer_prio < held_prio);
        take       = beats_run && beats_held;
        drop_src   = take && (slot == SLOT_SRC);
    end
endmodule

// File: rtl/irq_presenter.sv
module irq_presenter
    import pres_pkg::*;
#(
    parameter int SRC_W   = 24,
    parameter int PRIO_W  = 8,
    parameter int IPI_SRC = 2
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      offer_valid,
    input  logic [SRC_W-1:0]          offer_src,
    input  logic [PRIO_W-1:0]         offer_prio,
    input  logic                      cmd_valid,
    input  logic [1:0]                cmd_op,
    input  logic [SRC_W+PRIO_W-1:0]   cmd_data,
    output logic                      irq_out,
    output logic                      rsp_valid,
    output logic [SRC_W+PRIO_W-1:0]   rsp_word,
    output logic                      rej_valid,
    output logic [SRC_W-1:0]          rej_src,
    output logic                      eoi_valid,
    output logic [SRC_W-1:0]          eoi_src,
    output logic                      resend_req
);
    localparam int WORD_W = SRC_W + PRIO_W;
    localparam logic [PRIO_W-1:0] PRIO_NONE = '1;
    localparam logic [SRC_W-1:0]  SRC_NONE  = '0;
    localparam logic [SRC_W-1:0]  SRC_IPI   = SRC_W'(IPI_SRC);

    // state
    slot_e              slot_q, slot_d;
    logic [SRC_W-1:0]   src_q, src_d;
    logic [PRIO_W-1:0]  hprio_q, hprio_d;
    logic [PRIO_W-1:0]  run_q, run_d;
    logic [PRIO_W-1:0]  ipi_q, ipi_d;

    // registered strobes
    logic               rsp_v_q, rsp_v_d;
    logic [WORD_W-1:0]  rsp_w_q, rsp_w_d;
    logic               rej_v_q, rej_v_d;
    logic [SRC_W-1:0]   rej_s_q, rej_s_d;
    logic               eoi_v_q, eoi_v_d;
    logic [SRC_W-1:0]   eoi_s_q, eoi_s_d;
    logic               rsd_q, rsd_d;

    pres_op_e           op;
    logic [PRIO_W-1:0]  wr_prio;
    logic [PRIO_W-1:0]  chk_ipi;
    logic               chk_take, chk_drop;
    logic               off_take, off_drop;
    logic               do_resend;
    logic [PRIO_W-1:0]  new_run;

    assign op      = pres_op_e'(cmd_op);
    assign wr_prio = cmd_data[PRIO_W-1:0];
    assign chk_ipi = (cmd_valid && op == OP_SET_IPI) ? wr_prio : ipi_q;

    pres_ipi_check #(.PRIO_W(PRIO_W)) u_ipi (
        .slot      (slot_q),
        .held_prio (hprio_q),
        .ipi_prio  (chk_ipi),
        .take      (chk_take),
        .drop_src  (chk_drop)
    );

    pres_offer_judge #(.PRIO_W(PRIO_W)) u_judge (
        .slot       (slot_q),
        .run_prio   (run_q),
        .held_prio  (hprio_q),
        .offer_prio (offer_prio),
        .take       (off_take),
        .drop_src   (off_drop)
    );

    // next-state process
    always_comb begin
        slot_d    = slot_q;
        src_d     = src_q;
        hprio_d   = hprio_q;
        run_d     = run_q;
        ipi_d     = ipi_q;
        rsp_v_d   = 1'b0;
        rsp_w_d   = rsp_w_q;
        rej_v_d   = 1'b0;
        rej_s_d   = rej_s_q;
        eoi_v_d   = 1'b0;
        eoi_s_d   = eoi_s_q;
        rsd_d     = 1'b0;
        do_resend = 1'b0;
        new_run   = run_q;

        if (cmd_valid) begin
            unique case (op)
                OP_SET_RUN: begin
                    run_d   = wr_prio;
                    new_run = wr_prio;
                    if (wr_prio < run_q) begin
                        if (slot_q != SLOT_EMPTY && wr_prio <= hprio_q) begin
                            // transition displace_by_run
                            if (slot_q == SLOT_SRC) begin
                                rej_v_d = 1'b1;
                                rej_s_d = src_q;
                            end
                            slot_d  = SLOT_EMPTY;
                            src_d   = SRC_NONE;
                            hprio_d = PRIO_NONE;
                        end
                    end else if (slot_q == SLOT_EMPTY) begin
                        do_resend = 1'b1;
                    end
                end
                OP_SET_IPI: begin
                    ipi_d = wr_prio;
                    if (wr_prio < run_q && chk_take) begin
                        // transition present_ipi
                        if (chk_drop) begin
                            rej_v_d = 1'b1;
                            rej_s_d = src_q;
                        end
                        slot_d  = SLOT_IPI;
                        src_d   = SRC_IPI;
                        hprio_d = wr_prio;
                    end
                end
                OP_ACCEPT: begin
                    // transition accept
                    rsp_v_d = 1'b1;
                    rsp_w_d = {run_q, src_q};
                    run_d   = hprio_q;
                    slot_d  = SLOT_EMPTY;
                    src_d   = SRC_NONE;
                    hprio_d = PRIO_NONE;
                end
                OP_EOI: begin
                    run_d   = cmd_data[WORD_W-1:SRC_W];
                    new_run = cmd_data[WORD_W-1:SRC_W];
                    eoi_v_d = 1'b1;
                    eoi_s_d = cmd_data[SRC_W-1:0];
                    if (slot_q == SLOT_EMPTY) do_resend = 1'b1;
                end
            endcase
        end else if (offer_valid) begin
            if (off_take) begin
                // transition take_offer
                if (off_drop) begin
                    rej_v_d = 1'b1;
                    rej_s_d = src_q;
                end
                slot_d  = SLOT_SRC;
                src_d   = offer_src;
                hprio_d = offer_prio;
            end else begin
                rej_v_d = 1'b1;
                rej_s_d = offer_src;
            end
        end

        if (do_resend) begin
            rsd_d = 1'b1;
            // slot is empty here, so the check always grants
            if (ipi_q < new_run && chk_take) begin
                slot_d  = SLOT_IPI;
                src_d   = SRC_IPI;
                hprio_d = ipi_q;
            end
        end
    end

    // state register process
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slot_q  <= SLOT_EMPTY;
            src_q   <= SRC_NONE;
            hprio_q <= PRIO_NONE;
            run_q   <= '0;
            ipi_q   <= PRIO_NONE;
            rsp_v_q <= 1'b0;
            rsp_w_q <= '0;
            rej_v_q <= 1'b0;
            rej_s_q <= '0;
            eoi_v_q <= 1'b0;
            eoi_s_q <= '0;
            rsd_q   <= 1'b0;
        end else begin
            slot_q  <= slot_d;
            src_q   <= src_d;
            hprio_q <= hprio_d;
            run_q   <= run_d;
            ipi_q   <= ipi_d;
            rsp_v_q <= rsp_v_d;
            rsp_w_q <= rsp_w_d;
            rej_v_q <= rej_v_d;
            rej_s_q <= rej_s_d;
            eoi_v_q <= eoi_v_d;
            eoi_s_q <= eoi_s_d;
            rsd_q   <= rsd_d;
        end
    end

    // output process
    always_comb begin
        unique case (slot_q)
            SLOT_SRC, SLOT_IPI: irq_out = 1'b1;
            default:            irq_out = 1'b0;
        endcase
        rsp_valid  = rsp_v_q;
        rsp_word   = rsp_w_q;
        rej_valid  = rej_v_q;
        rej_src    = rej_s_q;
        eoi_valid  = eoi_v_q;
        eoi_src    = eoi_s_q;
        resend_req = rsd_q;
    end

    // assertions
    a_r4_displaced_rejected: assert property (@(posedge clk) disable iff (!rst_n)
        (offer_valid && !cmd_valid && slot_q == SLOT_SRC &&
         offer_prio < run_q && offer_prio < hprio_q)
        |=> (rej_valid && rej_src == $past(src_q)));

    a_r5_accept_returns: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && op == OP_ACCEPT)
        |=> (rsp_valid && !irq_out && rsp_word == {$past(run_q), $past(src_q)}));

    a_r10_eoi_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && op == OP_EOI)
        |=> (eoi_valid && eoi_src == $past(cmd_data[SRC_W-1:0])));

    a_r11_ipi_no_reject: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_q == SLOT_IPI && !cmd_valid && offer_valid && off_take)
        |=> !rej_valid);

    a_r12_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (!cmd_valid && !offer_valid)
        |=> (!rej_valid && !eoi_valid && !resend_req && !rsp_valid));

    a_r8_ipi_present: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && op == OP_SET_IPI && slot_q == SLOT_EMPTY && wr_prio < run_q)
        |=> (irq_out && src_q == SRC_IPI));
endmodule

// File: tb/sim_irq_presenter.sv
module sim_irq_presenter;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        offer_valid = 1'b0;
    logic [23:0] offer_src = '0;
    logic [7:0]  offer_prio = '0;
    logic        cmd_valid = 1'b0;
    logic [1:0]  cmd_op = '0;
    logic [31:0] cmd_data = '0;
    logic        irq_out, rsp_valid, rej_valid, eoi_valid, resend_req;
    logic [31:0] rsp_word;
    logic [23:0] rej_src, eoi_src;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #2 clk = ~clk;

    irq_presenter u0 (
        .clk(clk), .rst_n(rst_n),
        .offer_valid(offer_valid), .offer_src(offer_src), .offer_prio(offer_prio),
        .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_data(cmd_data),
        .irq_out(irq_out), .rsp_valid(rsp_valid), .rsp_word(rsp_word),
        .rej_valid(rej_valid), .rej_src(rej_src),
        .eoi_valid(eoi_valid), .eoi_src(eoi_src), .resend_req(resend_req)
    );

    task automatic ck(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic ck_eq(input string tag, input logic [31:0] act, input logic [31:0] exp);
        ck(act === exp, tag, act, exp);
    endtask

    task automatic cmd(input logic [1:0] op, input logic [31:0] data);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = op; cmd_data = data;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic offer(input logic [23:0] s, input logic [7:0] p);
        @(negedge clk);
        offer_valid = 1'b1; offer_src = s; offer_prio = p;
        @(negedge clk);
        offer_valid = 1'b0;
    endtask

    task automatic t_reset;
        ck_eq("R1 irq after reset", irq_out, 0);
        ck_eq("R1 strobes after reset", {rej_valid, eoi_valid, resend_req, rsp_valid}, 0);
        cmd(2'd2, 0);
        ck_eq("R1 first accept word", rsp_word, 32'h0000_0000);
        ck_eq("R1 first accept valid", rsp_valid, 1);
    endtask

    task automatic t_offers;
        offer(24'h123, 8'd5);
        ck_eq("R2 offer taken irq", irq_out, 1);
        ck_eq("R2 no reject", rej_valid, 0);
        offer(24'h200, 8'd5);
        ck_eq("R3 equal prio rejected", rej_valid, 1);
        ck_eq("R3 reject src", rej_src, 24'h200);
        offer(24'h300, 8'd3);
        ck_eq("R4 displaced reject", rej_valid, 1);
        ck_eq("R4 displaced src", rej_src, 24'h123);
        cmd(2'd2, 0);
        ck_eq("R5 accept word", rsp_word, 32'hFF00_0300);
        ck_eq("R5 line drops", irq_out, 0);
        offer(24'h310, 8'd3);
        ck_eq("R3 not below running", rej_valid, 1);
        ck_eq("R3 not below running src", rej_src, 24'h310);
        ck_eq("R3 slot unchanged", irq_out, 0);
    endtask

    task automatic t_eoi_ipi;
        cmd(2'd3, 32'hFF00_0300);
        ck_eq("R10 eoi strobe", eoi_valid, 1);
        ck_eq("R10 eoi src", eoi_src, 24'h300);
        ck_eq("R10 resend", resend_req, 1);
        ck_eq("R10 no ipi yet", irq_out, 0);
        cmd(2'd1, 32'h04);
        ck_eq("R8 ipi presented", irq_out, 1);
        ck_eq("R8 no reject", rej_valid, 0);
        cmd(2'd2, 0);
        ck_eq("R8 accept ipi word", rsp_word, 32'hFF00_0002);
        cmd(2'd3, 32'hFF00_0002);
        ck_eq("R10 resend after ipi eoi", resend_req, 1);
        ck_eq("R7 ipi re-presented on resend", irq_out, 1);
        offer(24'h40, 8'd6);
        ck_eq("R3 worse than held ipi", rej_src, 24'h40);
        cmd(2'd1, 32'h04);
        ck_eq("R9 check idle no reject", rej_valid, 0);
        ck_eq("R9 ipi still held", irq_out, 1);
        offer(24'h50, 8'd2);
        ck_eq("R11 no reject for ipi", rej_valid, 0);
        ck_eq("R11 offer holds line", irq_out, 1);
        cmd(2'd2, 0);
        ck_eq("R11 accept after displace", rsp_word, 32'hFF00_0050);
        cmd(2'd1, 32'h03);
        ck_eq("R8 not below running", irq_out, 0);
    endtask

    task automatic t_run_changes;
        cmd(2'd0, 32'h10);
        ck_eq("R7 resend on raise", resend_req, 1);
        ck_eq("R7 ipi on raise", irq_out, 1);
        cmd(2'd2, 0);
        ck_eq("R7 accept word", rsp_word, 32'h1000_0002);
        cmd(2'd1, 32'hFF);
        offer(24'h60, 8'd1);
        ck_eq("R2 taken under run 3", irq_out, 1);
        cmd(2'd0, 32'h01);
        ck_eq("R6 displace reject", rej_valid, 1);
        ck_eq("R6 displace src", rej_src, 24'h60);
        ck_eq("R6 line drops", irq_out, 0);
        ck_eq("R6 no resend", resend_req, 0);
        cmd(2'd2, 0);
        ck_eq("R5 empty accept word", rsp_word, 32'h0100_0000);
        offer(24'h70, 8'd5);
        cmd(2'd0, 32'h08);
        ck_eq("R6 lower without displace", irq_out, 1);
        ck_eq("R6 lower without displace rej", rej_valid, 0);
        cmd(2'd2, 0);
        ck_eq("R5 accept keeps new run", rsp_word, 32'h0800_0070);
        @(negedge clk);
        ck_eq("R12 strobes single cycle", {rej_valid, eoi_valid, resend_req, rsp_valid}, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_offers();
        t_eoi_ipi();
        t_run_changes();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=%h expected=%h", 0, 1);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end
endmodule